// File: doc/BRIEF.md
# Weighted Round-Robin DMA Bus Arbiter

This block decides which of two DMA engines, the receive engine and the transmit engine, may use a single shared host-bus master port. Each engine raises a request line and waits for its grant. The granted engine performs one transfer and then pulses a completion strobe. The grant is released on that strobe, and the block arbitrates again in the following cycle.

Each side has a 2-bit weight in a small configuration register. The weight sets how many consecutive transfers that side may win in one turn, so one engine can be favoured by a power-of-two ratio. When the holder's credits run out, or the holder stops requesting, the turn passes to the other engine if that engine is requesting. A separate configuration bit switches off the rotation. In that mode the receive engine wins every arbitration in which it is requesting.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: After reset both grants are low, the configuration register holds 0, and the receive side wins the first turn when both sides request.
- R2: At most one grant is high at any time, and a grant only rises for a side that was requesting in the cycle before.
- R3: A grant stays high until the cycle in which `xfer_done` is high and falls at the next clock edge. Arbitration happens only while no grant is high, so a new grant appears at the earliest one edge after the release.
- R4: Configuration bits [1:0] hold the receive weight and bits [3:2] hold the transmit weight. A weight value w gives 2^w transfers per turn (0→1, 1→2, 2→4, 3→8).
- R5: With rotation enabled, when the holder's credits are used up the next turn goes to the other side if it requests. Otherwise the same side starts a fresh turn with full credits.
- R6: If the holder is not requesting at an arbitration point, its turn ends at once. A requesting other side then starts a new turn.
- R7: Configuration bit 4 set disables rotation. The receive side then wins every arbitration in which it requests, and the transmit side wins only when the receive side is idle.
- R8: A weight written during a turn does not change the number of transfers left in that turn. The new weight is used only when a turn starts.
- R9: With neither side requesting at an arbitration point no grant is issued, and any partly used turn is abandoned.
- R10: A write through `cfg_we`/`cfg_wdata` updates the configuration register at the next clock edge and governs every later arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration data: {rotation off, tx weight, rx weight} |
| rx_req | input | 1 | Receive DMA request |
| tx_req | input | 1 | Transmit DMA request |
| xfer_done | input | 1 | One-cycle completion strobe from the granted engine |
| rx_gnt | output | 1 | Grant to the receive DMA engine |
| tx_gnt | output | 1 | Grant to the transmit DMA engine |

## Verification
The assertions assume that a granted engine keeps its request high until its transfer completes, and that `xfer_done` is pulsed only while a grant is high. The stimulus changes the request lines only in cycles with no grant. It raises the completion strobe only after observing a grant, for one cycle, after a random wait of zero to two cycles. Configuration writes are placed either inside a grant or while both sides are idle, so a write never races a pending arbitration. This includes writes in the middle of a multi-transfer turn.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    parameter int unsigned WT_W = 2;
    // largest credit budget is 2^(2^WT_W - 1); remaining count needs this many bits
    localparam int unsigned CRED_W = (1 << WT_W) - 1;
    localparam int unsigned CFG_W  = 2 * WT_W + 1;

    typedef enum logic {
        SIDE_RX = 1'b0,
        SIDE_TX = 1'b1
    } side_e;

    typedef struct packed {
        logic            rr_off;
        logic [WT_W-1:0] tx_wt;
        logic [WT_W-1:0] rx_wt;
    } arb_cfg_t;

    // credits remaining after the first grant of a turn: 2^wt - 1
    function automatic logic [CRED_W-1:0] spare_credits(input logic [WT_W-1:0] wt);
        logic [CRED_W:0] full;
        full     = '0;
        full[wt] = 1'b1;
        full     = full - {{CRED_W{1'b0}}, 1'b1};
        return full[CRED_W-1:0];
    endfunction

    function automatic side_e other_side(input side_e s);
        return (s == SIDE_RX) ? SIDE_TX : SIDE_RX;
    endfunction

endpackage

// File: rtl/wrr_cfg_reg.sv
module wrr_cfg_reg
    import wrr_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output arb_cfg_t         cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (we) begin
            cfg_o <= arb_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/wrr_turn_ctl.sv
module wrr_turn_ctl
    import wrr_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_cfg_t cfg,
    input  logic     rx_req,
    input  logic     tx_req,
    input  logic     arb_en,
    output logic     win_vld,
    output side_e    win_side
);

    side_e              holder_q;
    logic [CRED_W-1:0]  left_q;
    logic               live_q;

    logic               any_req;
    logic               hold_req;
    logic               oth_req;
    logic               keep_turn;
    logic [WT_W-1:0]    wt_sel;

    always_comb begin
        any_req   = rx_req | tx_req;
        hold_req  = (holder_q == SIDE_RX) ? rx_req : tx_req;
        oth_req   = (holder_q == SIDE_RX) ? tx_req : rx_req;
        keep_turn = live_q && (left_q != '0) && hold_req;

        if (cfg.rr_off) begin
            win_side = rx_req ? SIDE_RX : SIDE_TX;
        end else if (keep_turn) begin
            win_side = holder_q;
        end else if (oth_req) begin
            win_side = other_side(holder_q);
        end else begin
            win_side = holder_q;
        end

        wt_sel  = (win_side == SIDE_RX) ? cfg.rx_wt : cfg.tx_wt;
        win_vld = any_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            holder_q <= SIDE_TX;
            left_q   <= '0;
            live_q   <= 1'b0;
        end else if (arb_en) begin
            if (!any_req) begin
                live_q <= 1'b0;
            end else if (cfg.rr_off) begin
                live_q   <= 1'b0;
                holder_q <= win_side;
            end else if (keep_turn) begin
                left_q <= left_q - {{(CRED_W-1){1'b0}}, 1'b1};
            end else begin
                holder_q <= win_side;
                left_q   <= spare_credits(wt_sel);
                live_q   <= 1'b1;
            end
        end
    end

    // R8: the turn budget only moves at arbitration points, never during a grant
    a_r8_budget_frozen: assert property (@(posedge clk) disable iff (rst)
        !arb_en |=> $stable(left_q) && $stable(holder_q));

    // R9: an arbitration point without requests abandons any live turn
    a_r9_turn_dropped: assert property (@(posedge clk) disable iff (rst)
        (arb_en && !rx_req && !tx_req) |=> !live_q);

endmodule

// File: rtl/wrr_grant_reg.sv
module wrr_grant_reg
    import wrr_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_vld,
    input  side_e win_side,
    input  logic  xfer_done,
    output logic  rx_gnt,
    output logic  tx_gnt,
    output logic  idle
);

    assign idle = !(rx_gnt || tx_gnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_gnt <= 1'b0;
            tx_gnt <= 1'b0;
        end else if (idle) begin
            if (win_vld) begin
                rx_gnt <= (win_side == SIDE_RX);
                tx_gnt <= (win_side == SIDE_TX);
            end
        end else if (xfer_done) begin
            rx_gnt <= 1'b0;
            tx_gnt <= 1'b0;
        end
    end

    // R3: grant held until the completion strobe
    a_r3_hold_rx: assert property (@(posedge clk) disable iff (rst)
        (rx_gnt && !xfer_done) |=> rx_gnt);
    a_r3_hold_tx: assert property (@(posedge clk) disable iff (rst)
        (tx_gnt && !xfer_done) |=> tx_gnt);
    // R3: released at the edge after the strobe
    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (!idle && xfer_done) |=> idle);

endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter
    import wrr_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rx_req,
    input  logic             tx_req,
    input  logic             xfer_done,
    output logic             rx_gnt,
    output logic             tx_gnt
);

    arb_cfg_t cfg_q;
    logic     win_vld;
    side_e    win_side;
    logic     idle;

    wrr_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg_q)
    );

    wrr_turn_ctl u_turn (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .rx_req   (rx_req),
        .tx_req   (tx_req),
        .arb_en   (idle),
        .win_vld  (win_vld),
        .win_side (win_side)
    );

    wrr_grant_reg u_gnt (
        .clk       (clk),
        .rst       (rst),
        .win_vld   (win_vld),
        .win_side  (win_side),
        .xfer_done (xfer_done),
        .rx_gnt    (rx_gnt),
        .tx_gnt    (tx_gnt),
        .idle      (idle)
    );

    // R2: one grant at a time
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        !(rx_gnt && tx_gnt));
    // R2: grant only to a requester
    a_r2_rx_requested: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_gnt) |-> $past(rx_req));
    a_r2_tx_requested: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_gnt) |-> $past(tx_req));
    // R7: rotation off gives receive fixed priority
    a_r7_rx_priority: assert property (@(posedge clk) disable iff (rst)
        (idle && rx_req && cfg_q.rr_off) |=> rx_gnt);
    // R9: no requests, no grant
    a_r9_no_req_no_gnt: assert property (@(posedge clk) disable iff (rst)
        (idle && !rx_req && !tx_req) |=> (!rx_gnt && !tx_gnt));

endmodule

// File: tb/wrr_bus_arbiter_tb.sv
module wrr_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       rx_req = 1'b0;
    logic       tx_req = 1'b0;
    logic       xfer_done = 1'b0;
    logic       rx_gnt;
    logic       tx_gnt;

    int n_chk  = 0;
    int n_fail = 0;

    // reference state: holder 0 = rx, 1 = tx
    logic [4:0] m_cfg  = '0;
    int         m_hold = 1;
    int         m_left = 0;
    bit         m_live = 1'b0;

    always #5 clk = ~clk;

    wrr_bus_arbiter dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rx_req    (rx_req),
        .tx_req    (tx_req),
        .xfer_done (xfer_done),
        .rx_gnt    (rx_gnt),
        .tx_gnt    (tx_gnt)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic int gnt_code();
        if (rx_gnt && tx_gnt) return 3;
        if (rx_gnt) return 1;
        if (tx_gnt) return 2;
        return 0;
    endfunction

    // expected winner per R4..R9: 0 none, 1 rx, 2 tx
    function automatic int model_arb(input bit r, input bit t);
        int w;
        bit hreq;
        bit oreq;
        if (!r && !t) begin
            m_live = 1'b0;
            return 0;
        end
        if (m_cfg[4]) begin
            m_live = 1'b0;
            m_hold = r ? 0 : 1;
            return m_hold + 1;
        end
        hreq = (m_hold == 0) ? r : t;
        oreq = (m_hold == 0) ? t : r;
        if (m_live && m_left != 0 && hreq) begin
            m_left--;
            return m_hold + 1;
        end
        if (oreq) m_hold = 1 - m_hold;
        w      = (m_hold == 0) ? int'(m_cfg[1:0]) : int'(m_cfg[3:2]);
        m_left = (1 << w) - 1;
        m_live = 1'b1;
        return m_hold + 1;
    endfunction

    task automatic step(input bit r, input bit t, input bit wr,
                        input logic [4:0] wd, input string tag);
        int exp;
        int hold;
        rx_req = r;
        tx_req = t;
        @(posedge clk);
        @(negedge clk);
        exp = model_arb(r, t);
        check(gnt_code() == exp, tag, gnt_code(), exp);
        if (wr) begin
            cfg_we    = 1'b1;
            cfg_wdata = wd;
            @(negedge clk);
            cfg_we    = 1'b0;
            m_cfg     = wd;
            if (exp == 0) void'(model_arb(r, t));
        end
        if (exp != 0) begin
            hold = $urandom_range(0, 2);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(gnt_code() == exp, "R3 grant held", gnt_code(), exp);
            end
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            check(gnt_code() == 0, "R3 released after done", gnt_code(), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog got=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(gnt_code() == 0, "R1 reset grants", gnt_code(), 0);
        step(0, 0, 0, '0, "R9 idle no grant");
        // R1/R5: default weights alternate one for one, rx first
        for (int i = 0; i < 4; i++) step(1, 1, 0, '0, "R1 R5 default alternation");
        // R4/R10: rx weight 1 gives 2:1
        step(1, 1, 1, 5'b00001, "R10 write during grant");
        for (int i = 0; i < 7; i++) step(1, 1, 0, '0, "R4 rx weight 1");
        // R4: tx weight 3 gives eight per turn
        step(0, 0, 1, 5'b01100, "R10 write idle");
        for (int i = 0; i < 12; i++) step(1, 1, 0, '0, "R4 tx weight 3");
        // R8: shrink rx weight in the middle of an 8-credit rx turn
        step(0, 0, 1, 5'b00011, "R8 setup");
        step(1, 1, 0, '0, "R8 turn start");
        step(1, 1, 1, 5'b00000, "R8 write mid turn");
        for (int i = 0; i < 9; i++) step(1, 1, 0, '0, "R8 budget kept");
        // R6: holder drops its request
        step(0, 0, 1, 5'b00010, "R6 setup");
        step(1, 1, 0, '0, "R6 rx turn");
        step(0, 1, 0, '0, "R6 rx dropped");
        step(1, 1, 0, '0, "R6 after drop");
        // R5: lone requester renews its turn
        step(0, 0, 1, 5'b00000, "R5 setup");
        for (int i = 0; i < 3; i++) step(1, 0, 0, '0, "R5 lone rx");
        // R7: rotation off
        step(0, 0, 1, 5'b10000, "R7 setup");
        for (int i = 0; i < 3; i++) step(1, 1, 0, '0, "R7 rx priority");
        step(0, 1, 0, '0, "R7 tx when rx idle");
        step(1, 1, 0, '0, "R7 rx again");
        // mixed random
        for (int i = 0; i < 400; i++) begin
            int k;
            bit r;
            bit t;
            bit wr;
            k  = $urandom_range(0, 5);
            r  = (k == 0) ? 1'b0 : (k != 5);
            t  = (k == 0) ? 1'b0 : (k != 4);
            wr = ($urandom_range(0, 7) == 0);
            step(r, t, wr, 5'($urandom_range(0, 31)), "R4 R5 R6 R7 R8 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule